// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns the operand fields of a memory instruction into a 64-bit effective address. Each request carries five inputs: a 3-bit mode code, a signed constant, a base register value, an index register value and a 2-bit operand size code. The block supports six ways of forming the address. They range from using the constant alone, through sums in which one register is scaled by the operand size, to a pointer chase that reads the final address out of memory.

Every mode except the pointer chase returns its result exactly one cycle after the request is accepted. The pointer chase issues a read on a simple request/acknowledge port. It holds that read until memory acknowledges, and then presents the loaded word as the address on the following cycle. While a read is outstanding the block deasserts `req_ready` and ignores new requests. Mode codes that no mode uses raise a one-cycle illegal flag instead of an address.

Top module: `eaddr_gen`

## Requirements
- R1: After reset `ea_valid`, `ea_illegal` and `mem_rd_req` are low and `req_ready` is high.
- R2: Mode 0 (absolute): one cycle after acceptance, `ea_valid` pulses and `ea_addr` equals the constant sign-extended from 32 to 64 bits.
- R3: Mode 1 (register indirect): one cycle after acceptance, `ea_addr` equals `req_base`.
- R4: Mode 2 (displacement): `ea_addr` equals the sign-extended constant plus `req_base` shifted left by the size code.
- R5: Mode 3 (indexed): `ea_addr` equals `req_base` plus `req_index` shifted left by the size code.
- R6: Mode 4 (scaled): `ea_addr` equals the sign-extended constant plus `req_base` plus `req_index` shifted left by the size code.
- R7: Size codes 0, 1, 2 and 3 stand for 1, 2, 4 and 8 bytes, so they scale by a left shift of 0, 1, 2 and 3 bits. Every sum wraps modulo 2^64.
- R8: Mode 5 (memory indirect): one cycle after acceptance, `mem_rd_req` rises with `mem_rd_addr` equal to `req_base`. Both stay unchanged until the cycle in which `mem_rd_ack` is high.
- R9: In the cycle after `mem_rd_req` and `mem_rd_ack` are both high, `ea_valid` pulses, `ea_addr` equals the `mem_rd_data` sampled with the acknowledge, and `mem_rd_req` is low.
- R10: Mode codes 6 and 7 produce a one-cycle `ea_illegal` pulse one cycle after acceptance. They produce no `ea_valid` and no memory read.
- R11: While a memory read is outstanding, `req_ready` is low and a request has no effect: it produces no `ea_valid` or `ea_illegal`, and `mem_rd_addr` is left unchanged.
- R12: `ea_valid` and `ea_illegal` last one cycle each when no new request is accepted, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 3 | Addressing mode code |
| req_const | input | 32 | Signed constant field |
| req_base | input | 64 | Base register value |
| req_index | input | 64 | Index register value |
| req_size | input | 2 | Operand size code (log2 of bytes) |
| ea_valid | output | 1 | Effective address valid pulse |
| ea_addr | output | 64 | Effective address |
| ea_illegal | output | 1 | Unused mode code pulse |
| mem_rd_req | output | 1 | Pointer read request |
| mem_rd_addr | output | 64 | Pointer read address |
| mem_rd_ack | input | 1 | Pointer read acknowledge |
| mem_rd_data | input | 64 | Pointer read data |

## Verification
The bench drives negative constants and base values near 2^64. A design that zero-extends the constant or clips the carry would return an address off by 2^32 or one that does not wrap. It uses every size code on both the displacement and the indexed modes. A shift taken from the wrong register, or a byte count used as the shift amount, would land on a different address. For the pointer chase it waits a random number of cycles before the acknowledge and fires requests during that wait. A design that drops the read early, latches the data late or accepts a request while busy would show a wrong or extra output. Codes 6 and 7 are checked for an illegal pulse with no read and no address.

// File: rtl/eag_pkg.sv
// Package: shared widths and the mode encoding for the effective address generator.
// Assumes 64-bit addresses and a 2-bit log2 size code.
package eag_pkg;
    localparam int MODE_W = 3;
    localparam int SIZE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        AM_ABS    = 3'd0,
        AM_REGIND = 3'd1,
        AM_DISP   = 3'd2,
        AM_INDEX  = 3'd3,
        AM_SCALED = 3'd4,
        AM_MEMIND = 3'd5
    } addr_mode_e;
endpackage

// File: rtl/eag_calc.sv
// eag_calc: combinational address arithmetic for the modes that need no memory.
// Sign-extends the constant, scales by a left shift of the size code, and
// flags the pointer-chase mode and the unused codes. All sums wrap.
module eag_calc
    import eag_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int CONST_W = 32
) (
    input  logic [MODE_W-1:0]  mode,
    input  logic [CONST_W-1:0] cnst,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  index,
    input  logic [SIZE_W-1:0]  size,
    output logic [ADDR_W-1:0]  addr,
    output logic               is_mem,
    output logic               is_illegal
);
    localparam int EXT_W = ADDR_W - CONST_W;

    logic [ADDR_W-1:0] cnst_sx;
    logic [ADDR_W-1:0] base_sc;
    logic [ADDR_W-1:0] index_sc;

    // Widen the constant and form the size-scaled register terms.
    always_comb begin
        cnst_sx  = {{EXT_W{cnst[CONST_W-1]}}, cnst};
        base_sc  = base << size;
        index_sc = index << size;
    end

    // Pick the sum that the mode code selects.
    always_comb begin
        addr       = '0;
        is_mem     = 1'b0;
        is_illegal = 1'b0;
        case (mode)
            AM_ABS:    addr = cnst_sx;
            AM_REGIND: addr = base;
            AM_DISP:   addr = cnst_sx + base_sc;
            AM_INDEX:  addr = base + index_sc;
            AM_SCALED: addr = cnst_sx + base + index_sc;
            AM_MEMIND: begin
                addr   = base;
                is_mem = 1'b1;
            end
            default:   is_illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/eag_seq.sv
// eag_seq: request acceptance, output registers and the pointer-read handshake.
// Assumes memory holds mem_rd_data valid in the cycle mem_rd_ack is high.
module eag_seq #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              is_mem,
    input  logic              is_illegal,
    input  logic [ADDR_W-1:0] calc_addr,
    input  logic              mem_rd_ack,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              req_ready,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ea_addr,
    output logic              ea_illegal,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr
);
    typedef enum logic {ST_IDLE, ST_WAIT} seq_state_e;

    seq_state_e state;
    logic       accept;

    // A request is taken only while no pointer read is pending.
    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_valid && req_ready;
    end

    // Advance state, launch pointer reads and register results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            ea_valid    <= 1'b0;
            ea_addr     <= '0;
            ea_illegal  <= 1'b0;
            mem_rd_req  <= 1'b0;
            mem_rd_addr <= '0;
        end else begin
            ea_valid   <= 1'b0;
            ea_illegal <= 1'b0;
            if (state == ST_IDLE) begin
                if (accept) begin
                    if (is_illegal) begin
                        ea_illegal <= 1'b1;
                    end else if (is_mem) begin
                        mem_rd_req  <= 1'b1;
                        mem_rd_addr <= calc_addr;
                        state       <= ST_WAIT;
                    end else begin
                        ea_valid <= 1'b1;
                        ea_addr  <= calc_addr;
                    end
                end
            end else if (mem_rd_ack) begin
                mem_rd_req <= 1'b0;
                ea_valid   <= 1'b1;
                ea_addr    <= mem_rd_data;
                state      <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/eaddr_gen.sv
// eaddr_gen: top of the multi-mode effective address generator.
// Wires the arithmetic stage to the sequencing stage; no logic of its own.
module eaddr_gen
    import eag_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int CONST_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [MODE_W-1:0]  req_mode,
    input  logic [CONST_W-1:0] req_const,
    input  logic [ADDR_W-1:0]  req_base,
    input  logic [ADDR_W-1:0]  req_index,
    input  logic [SIZE_W-1:0]  req_size,
    output logic               ea_valid,
    output logic [ADDR_W-1:0]  ea_addr,
    output logic               ea_illegal,
    output logic               mem_rd_req,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_ack,
    input  logic [ADDR_W-1:0]  mem_rd_data
);
    logic [ADDR_W-1:0] calc_addr;
    logic              is_mem;
    logic              is_illegal;

    eag_calc #(.ADDR_W(ADDR_W), .CONST_W(CONST_W)) u_calc (
        .mode       (req_mode),
        .cnst       (req_const),
        .base       (req_base),
        .index      (req_index),
        .size       (req_size),
        .addr       (calc_addr),
        .is_mem     (is_mem),
        .is_illegal (is_illegal)
    );

    eag_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .is_mem      (is_mem),
        .is_illegal  (is_illegal),
        .calc_addr   (calc_addr),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data),
        .req_ready   (req_ready),
        .ea_valid    (ea_valid),
        .ea_addr     (ea_addr),
        .ea_illegal  (ea_illegal),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr)
    );
endmodule

// File: rtl/eag_checker.sv
// eag_checker: protocol properties of eaddr_gen, bound to every instance.
module eag_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_mode,
    input logic              ea_valid,
    input logic [ADDR_W-1:0] ea_addr,
    input logic              ea_illegal,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_ack,
    input logic [ADDR_W-1:0] mem_rd_data
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !ea_valid && !ea_illegal && !mem_rd_req && req_ready);

    assert_direct_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_mode < 3'd5 |=> ea_valid && !ea_illegal);

    assert_read_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));

    assert_read_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_mode == 3'd5 |=> mem_rd_req && !ea_valid);

    assert_ack_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && mem_rd_ack |=> ea_valid && !mem_rd_req && ea_addr == $past(mem_rd_data));

    assert_illegal_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_mode > 3'd5 |=> ea_illegal && !ea_valid && !mem_rd_req);

    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready);

    assert_exclusive_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ea_valid && ea_illegal));
endmodule

bind eaddr_gen eag_checker #(.ADDR_W(ADDR_W)) u_eag_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_mode    (req_mode),
    .ea_valid    (ea_valid),
    .ea_addr     (ea_addr),
    .ea_illegal  (ea_illegal),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_data (mem_rd_data)
);

// File: tb/tb_eaddr_gen.sv
// tb_eaddr_gen: seeded random plus directed stimulus against bench-side models.
module tb_eaddr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_mode = '0;
    logic [31:0] req_const = '0;
    logic [63:0] req_base = '0;
    logic [63:0] req_index = '0;
    logic [1:0]  req_size = '0;
    logic        ea_valid;
    logic [63:0] ea_addr;
    logic        ea_illegal;
    logic        mem_rd_req;
    logic [63:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [63:0] mem_rd_data = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    eaddr_gen dut (.*);

    // Model of the arithmetic modes 0..4.
    function automatic logic [63:0] model_ea(input logic [2:0] m, input logic [31:0] c,
                                             input logic [63:0] b, input logic [63:0] x,
                                             input logic [1:0] s);
        logic [63:0] cs;
        logic [63:0] mul;
        cs  = {{32{c[31]}}, c};
        mul = 64'd1 << s;
        case (m)
            3'd0:    return cs;
            3'd1:    return b;
            3'd2:    return cs + b * mul;
            3'd3:    return b + x * mul;
            default: return cs + b + x * mul;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] m, input logic [31:0] c, input logic [63:0] b,
                         input logic [63:0] x, input logic [1:0] s);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_const = c;
        req_base = b; req_index = x; req_size = s;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic direct(input string req, input logic [2:0] m, input logic [31:0] c,
                          input logic [63:0] b, input logic [63:0] x, input logic [1:0] s);
        issue(m, c, b, x, s);
        check({req, " valid"}, {63'd0, ea_valid}, 64'd1);
        check(req, ea_addr, model_ea(m, c, b, x, s));
    endtask

    task automatic pointer_chase(input logic [63:0] b, input logic [63:0] data, input int wait_n);
        issue(3'd5, $urandom, b, {$urandom, $urandom}, 2'($urandom));
        check("R8 rd_req", {63'd0, mem_rd_req}, 64'd1);
        check("R8 rd_addr", mem_rd_addr, b);
        check("R8 no valid", {63'd0, ea_valid}, 64'd0);
        for (int w = 0; w < wait_n; w++) begin
            req_valid = 1'b1; req_mode = 3'($urandom_range(0, 7)); req_base = ~b;
            @(negedge clk);
            req_valid = 1'b0;
            check("R11 ready low", {63'd0, req_ready}, 64'd0);
            check("R11 ignored", {62'd0, ea_valid, ea_illegal}, 64'd0);
            check("R8 held", {mem_rd_addr[62:0], mem_rd_req}, {b[62:0], 1'b1});
        end
        mem_rd_ack = 1'b1; mem_rd_data = data;
        @(negedge clk);
        mem_rd_ack = 1'b0; mem_rd_data = ~data;
        check("R9 valid", {62'd0, ea_valid, mem_rd_req}, 64'd2);
        check("R9 addr", ea_addr, data);
        check("R9 ready back", {63'd0, req_ready}, 64'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {60'd0, ea_valid, ea_illegal, mem_rd_req, req_ready}, 64'd1);

        // Directed corners.
        direct("R2 negative", 3'd0, 32'h8000_0000, '1, '1, 2'd3);
        direct("R2 positive", 3'd0, 32'h7fff_fff0, '0, '0, 2'd0);
        direct("R3", 3'd1, 32'hdead_beef, 64'h0123_4567_89ab_cdef, '1, 2'd2);
        for (int s = 0; s < 4; s++) begin
            direct("R4 R7 size", 3'd2, 32'hffff_fffc, 64'h0000_0000_0000_1001, '0, 2'(s));
            direct("R5 R7 size", 3'd3, 32'd0, 64'h100, 64'h8000_0000_0000_0003, 2'(s));
        end
        direct("R6 R7 wrap", 3'd4, 32'hffff_ffff, 64'hffff_ffff_ffff_fff0, 64'h4, 2'd3);
        @(negedge clk);
        check("R12 pulse", {62'd0, ea_valid, ea_illegal}, 64'd0);

        // R10 unused codes.
        for (int m = 6; m < 8; m++) begin
            issue(3'(m), $urandom, {$urandom, $urandom}, '0, 2'd1);
            check("R10", {61'd0, ea_illegal, ea_valid, mem_rd_req}, 64'd4);
            @(negedge clk);
            check("R12 illegal pulse", {63'd0, ea_illegal}, 64'd0);
        end

        // R8 R9 R11 pointer chase, including zero-wait acknowledge.
        pointer_chase(64'hffff_0000_1234_5678, 64'h0000_7777_8888_9999, 0);
        pointer_chase(64'h8, 64'hffff_ffff_ffff_fff8, 3);

        // Random mix.
        for (int i = 0; i < 300; i++) begin
            logic [2:0]  m;
            logic [31:0] c;
            logic [63:0] b;
            logic [63:0] x;
            logic [1:0]  s;
            m = 3'($urandom_range(0, 7));
            c = $urandom; b = {$urandom, $urandom}; x = {$urandom, $urandom};
            s = 2'($urandom);
            if (m == 3'd5) begin
                pointer_chase(b, {$urandom, $urandom}, int'($urandom_range(0, 4)));
            end else if (m > 3'd5) begin
                issue(m, c, b, x, s);
                check("R10 random", {62'd0, ea_illegal, ea_valid}, 64'd2);
            end else begin
                direct("R2-R7 random mode", m, c, b, x, s);
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule